// File: doc/BRIEF.md
# Edge-Triggered Interrupt Cause Unit

This unit sits beside a serial controller and watches thirteen live status levels. Whenever one of those levels goes from low to high, the matching cause bit is latched and held until software writes a one to it. A mask register chooses which pending causes reach the single interrupt line. The interrupt line is registered, so it is a clean flop output.

The live levels are also passed straight through on a separate output. Software can therefore read a condition directly before it arms the mask. This matters because a level that is already high when the mask opens never produces a fresh cause. Only a new rising edge does.

Top module: `edge_irq_unit`

## Requirements
- R1: When status bit i is sampled high at a clock edge and was sampled low at the previous edge, cause bit i reads 1 after that edge.
- R2: A status bit that stays high sets no new cause. After it is cleared, the cause stays 0 for as long as the level remains high.
- R3: Writing the cause register (wr strobe high) clears every cause bit whose data bit is 1. Bits written 0 keep their value.
- R4: If a rising edge and a clear hit the same cause bit in the same cycle, the bit ends up set.
- R5: A mask write stores the written value into the mask after that edge. Writing the mask never changes any cause bit.
- R6: The interrupt output is a flop. It reads 1 one cycle after any bit is set in both the cause register and the mask register, and 0 one cycle after no such bit remains.
- R7: The level output equals the status input at all times, whatever the cause and mask state.
- R8: Reset clears the causes, the mask, the interrupt and the stored previous levels. A status bit that is high when reset is released therefore sets its cause at the first edge after reset.
- R9: Cause bit i follows status bit i. The bit positions are:
  - bit 0: transfer done
  - bit 1: transfer ready
  - bit 2: receive queue ready
  - bit 3: send queue ready
  - bit 4: receive queue empty
  - bit 5: receive queue full
  - bit 6: send queue empty
  - bit 7: send queue full
  - bits 8 to 11: the four queue overflow and underflow flags
  - bit 12: address not set up

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| status_i | input | 13 | Live status levels from the controller |
| cause_wr_i | input | 1 | Strobe for a write-one-to-clear access to the cause register |
| cause_wdata_i | input | 13 | Clear pattern: each 1 clears that cause bit |
| mask_wr_i | input | 1 | Strobe for a write to the mask register |
| mask_wdata_i | input | 13 | New mask value |
| level_o | output | 13 | Live status readback |
| cause_o | output | 13 | Pending cause bits |
| mask_o | output | 13 | Current mask |
| irq_o | output | 1 | Registered interrupt request |

## Verification
A stale previous-level register shows up in two ways. Either a cause appears on a level that never fell, or an edge is missed. Both are visible on the cause output one edge after the status change.

A clear that takes the wrong bits, or that beats a simultaneous edge, shows on the cause output one edge after the write. A fault in the mask or in the output combine shows on the interrupt line one cycle later than on the cause and mask outputs.

Because the reference model follows every cycle, any of these faults is reported within two clocks of the stimulus that exposes it.

// File: rtl/irq_cause_pkg.sv
package irq_cause_pkg;
  localparam int unsigned NUM_STATUS = 13;

  // Status bit positions; cause bit i tracks status bit i.
  localparam int unsigned ST_XFER_DONE  = 0;
  localparam int unsigned ST_XFER_READY = 1;
  localparam int unsigned ST_RXQ_READY  = 2;
  localparam int unsigned ST_TXQ_READY  = 3;
  localparam int unsigned ST_ADDR_UNSET = 12;
endpackage

// File: rtl/cause_edge_detect.sv
module cause_edge_detect #(
  parameter int unsigned W = 13
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] level_i,
  output logic [W-1:0] rise_o
);
  logic [W-1:0] prev_q;

  function automatic logic [W-1:0] rising(input logic [W-1:0] cur,
                                          input logic [W-1:0] prev);
    return cur & ~prev;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= level_i;
  end

  assign rise_o = rising(level_i, prev_q);

  // R2: a level that was already high last cycle reports no edge
  assert_no_edge_on_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((rise_o & $past(level_i)) == '0));
endmodule

// File: rtl/cause_latch_bank.sv
module cause_latch_bank #(
  parameter int unsigned W = 13
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_i,
  input  logic         clr_en_i,
  input  logic [W-1:0] clr_bits_i,
  output logic [W-1:0] cause_o
);
  logic [W-1:0] clr_w;

  function automatic logic next_bit(input logic cur, input logic set,
                                    input logic clr);
    // a fresh edge outranks a clear in the same cycle
    return set | (cur & ~clr);
  endfunction

  assign clr_w = clr_en_i ? clr_bits_i : '0;

  for (genvar b = 0; b < W; b++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cause_o[b] <= 1'b0;
      else        cause_o[b] <= next_bit(cause_o[b], set_i[b], clr_w[b]);
    end
  end

  assert_set_wins_R1: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((cause_o & $past(set_i)) == $past(set_i)));
  assert_clear_hits_R3: assert property (@(posedge clk) disable iff (!rst_n)
    clr_en_i |=> ((cause_o & $past(clr_bits_i & ~set_i)) == '0));
  assert_edge_beats_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    clr_en_i |=> ((cause_o & $past(clr_bits_i & set_i)) == $past(clr_bits_i & set_i)));
  assert_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_en_i |=> ((cause_o & $past(cause_o)) == $past(cause_o)));
endmodule

// File: rtl/irq_mask_reg.sv
module irq_mask_reg #(
  parameter int unsigned W = 13
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] mask_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    mask_o <= '0;
    else if (wr_i) mask_o <= wdata_i;
  end

  assert_mask_store_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_i |=> (mask_o == $past(wdata_i)));
  assert_mask_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_i |=> $stable(mask_o));
endmodule

// File: rtl/edge_irq_unit.sv
module edge_irq_unit #(
  parameter int unsigned NUM_SRC = irq_cause_pkg::NUM_STATUS
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] status_i,
  input  logic               cause_wr_i,
  input  logic [NUM_SRC-1:0] cause_wdata_i,
  input  logic               mask_wr_i,
  input  logic [NUM_SRC-1:0] mask_wdata_i,
  output logic [NUM_SRC-1:0] level_o,
  output logic [NUM_SRC-1:0] cause_o,
  output logic [NUM_SRC-1:0] mask_o,
  output logic               irq_o
);
  logic [NUM_SRC-1:0] rise_w;
  logic [NUM_SRC-1:0] cause_w;
  logic [NUM_SRC-1:0] mask_w;
  logic               pending_w;

  function automatic logic any_enabled(input logic [NUM_SRC-1:0] c,
                                       input logic [NUM_SRC-1:0] m);
    return |(c & m);
  endfunction

  cause_edge_detect #(.W(NUM_SRC)) u_edge (
    .clk     (clk),
    .rst_n   (rst_n),
    .level_i (status_i),
    .rise_o  (rise_w)
  );

  cause_latch_bank #(.W(NUM_SRC)) u_latch (
    .clk        (clk),
    .rst_n      (rst_n),
    .set_i      (rise_w),
    .clr_en_i   (cause_wr_i),
    .clr_bits_i (cause_wdata_i),
    .cause_o    (cause_w)
  );

  irq_mask_reg #(.W(NUM_SRC)) u_mask (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_i    (mask_wr_i),
    .wdata_i (mask_wdata_i),
    .mask_o  (mask_w)
  );

  assign pending_w = any_enabled(cause_w, mask_w);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_o <= 1'b0;
    else        irq_o <= pending_w;
  end

  assign level_o = status_i;
  assign cause_o = cause_w;
  assign mask_o  = mask_w;

  assert_irq_follows_R6: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq_o == |($past(cause_w) & $past(mask_w))));
  assert_mask_keeps_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_wr_i && !cause_wr_i) |=> ((cause_w & $past(cause_w)) == $past(cause_w)));
  assert_only_edges_set_R1: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((cause_w & ~$past(cause_w) & ~$past(rise_w)) == '0));
endmodule

// File: tb/edge_irq_unit_test.sv
module edge_irq_unit_test;
  localparam int N = 13;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] status_i = '0;
  logic         cause_wr_i = 1'b0;
  logic [N-1:0] cause_wdata_i = '0;
  logic         mask_wr_i = 1'b0;
  logic [N-1:0] mask_wdata_i = '0;
  logic [N-1:0] level_o, cause_o, mask_o;
  logic         irq_o;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  // behavioural reference state
  int m_cause = 0, m_mask = 0, m_prev = 0, m_irq = 0;

  always #4 clk = ~clk;

  edge_irq_unit uut (
    .clk(clk), .rst_n(rst_n), .status_i(status_i),
    .cause_wr_i(cause_wr_i), .cause_wdata_i(cause_wdata_i),
    .mask_wr_i(mask_wr_i), .mask_wdata_i(mask_wdata_i),
    .level_o(level_o), .cause_o(cause_o), .mask_o(mask_o), .irq_o(irq_o)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    check(int'(cause_o) == m_cause, "R1 cause", int'(cause_o), m_cause);
    check(int'(mask_o) == m_mask, "R5 mask", int'(mask_o), m_mask);
    check(int'(irq_o) == m_irq, "R6 irq", int'(irq_o), m_irq);
    check(level_o == status_i, "R7 level", int'(level_o), int'(status_i));
  endtask

  // one clock: advance the model at the edge, compare shortly after
  task automatic step();
    int st, clr, nxt_irq;
    @(posedge clk);
    st = int'(status_i);
    clr = cause_wr_i ? int'(cause_wdata_i) : 0;
    if (!rst_n) begin
      m_cause = 0; m_mask = 0; m_prev = 0; m_irq = 0;
    end else begin
      nxt_irq = ((m_cause & m_mask) != 0) ? 1 : 0;
      m_cause = (m_cause & ~clr) | (st & ~m_prev);
      m_prev = st;
      if (mask_wr_i) m_mask = int'(mask_wdata_i);
      m_irq = nxt_irq;
    end
    #2;
    compare_all();
    cause_wr_i = 1'b0;
    mask_wr_i = 1'b0;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    // R8: reset state, with a level already high
    status_i = 13'h0004;
    step(); step();
    check(cause_o == '0 && mask_o == '0 && irq_o == 1'b0, "R8 reset",
          int'({cause_o, mask_o, irq_o}), 0);
    rst_n = 1'b1;
    step();
    check(cause_o == 13'h0004, "R8 level high at release", int'(cause_o), 'h4);

    // R2: clear all, hold level high
    cause_wr_i = 1'b1; cause_wdata_i = 13'h1fff;
    step();
    for (int i = 0; i < 4; i++) step();
    check(cause_o == '0, "R2 held level", int'(cause_o), 0);

    // R9: bit 0 (transfer done) and bit 12 (address not set up)
    status_i = 13'h0005;
    step();
    check(cause_o == 13'h0001, "R9 bit0", int'(cause_o), 'h1);
    status_i = 13'h1005;
    step();
    check(cause_o == 13'h1001, "R9 bit12", int'(cause_o), 'h1001);

    // R3: partial clear
    cause_wr_i = 1'b1; cause_wdata_i = 13'h0001;
    step();
    check(cause_o == 13'h1000, "R3 partial clear", int'(cause_o), 'h1000);

    // R4: edge and clear on bit 5 together
    status_i = 13'h1025;
    cause_wr_i = 1'b1; cause_wdata_i = 13'h0020;
    step();
    check(cause_o == 13'h1020, "R4 edge wins", int'(cause_o), 'h1020);

    // R6: mask enables irq one cycle after the mask lands
    mask_wr_i = 1'b1; mask_wdata_i = 13'h0020;
    step();
    check(irq_o == 1'b0, "R6 irq not yet", int'(irq_o), 0);
    step();
    check(irq_o == 1'b1, "R6 irq raised", int'(irq_o), 1);

    // R5: masking everything keeps causes
    mask_wr_i = 1'b1; mask_wdata_i = '0;
    step();
    check(cause_o == 13'h1020, "R5 mask keeps causes", int'(cause_o), 'h1020);
    step();
    check(irq_o == 1'b0, "R6 irq dropped", int'(irq_o), 0);

    // random traffic against the model
    for (int i = 0; i < 400; i++) begin
      status_i = N'($urandom);
      if (($urandom % 4) == 0) begin
        cause_wr_i = 1'b1; cause_wdata_i = N'($urandom);
      end
      if (($urandom % 5) == 0) begin
        mask_wr_i = 1'b1; mask_wdata_i = N'($urandom);
      end
      step();
    end
    finish_run();
  end
endmodule